// File: doc/BRIEF.md
# Universal Shift Register with Shared Parallel Bus

This block is an eight-bit storage register with four behaviours: keep its value, shift toward the high bit, shift toward the low bit, or take a new word from a parallel bus. A two-bit mode input selects the behaviour, and the register changes on the rising clock edge. Each shift direction has its own serial input, which fills the vacated end bit.

Parallel data goes in and comes out on one bidirectional bus. Here that bus is split into an input vector, an output vector and one output-enable flag. The bus is driven only when both active-low enables are low and the block is not in load mode. Load mode always releases the bus, so an outside source can place data on it without contention.

The lowest and highest bits are also sent to dedicated serial outputs that are always driven. These outputs let several stages be chained into one wider shifter. An active-low asynchronous reset clears the register.

Top module: `univ_shift_reg`

## Requirements
- R1: While rst_ni is low, the register is all zeros, bus_o reads 0, and lsb_o and msb_o are 0. This takes effect at once, without waiting for a clock edge.
- R2: With mode_i = 2'b00 (hold), a rising edge leaves the register unchanged. Serial inputs and bus_i have no effect.
- R3: With mode_i = 2'b11 (load), a rising edge copies bus_i into the register.
- R4: With mode_i = 2'b01 (shift up), a rising edge moves each bit n into bit n+1 and places ser_up_i in bit 0.
- R5: With mode_i = 2'b10 (shift down), a rising edge moves each bit n into bit n-1 and places ser_dn_i in bit 7.
- R6: bus_oe_o is 1 only when oe_a_ni and oe_b_ni are both 0 and mode_i is not 2'b11. While it is 1, the bus carries the register contents (bus_o).
- R7: lsb_o always equals bit 0 and msb_o always equals bit 7, whatever the output enables are.
- R8: Two stages can be chained into a 16-bit shifter in either direction. For upward shifts, the low stage's msb_o feeds the high stage's ser_up_i. For downward shifts, the high stage's lsb_o feeds the low stage's ser_dn_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | Mode: 00 hold, 01 shift up, 10 shift down, 11 load |
| ser_up_i | input | 1 | Serial bit entering bit 0 on an upward shift |
| ser_dn_i | input | 1 | Serial bit entering bit 7 on a downward shift |
| oe_a_ni | input | 1 | Bus output enable A, active low |
| oe_b_ni | input | 1 | Bus output enable B, active low |
| bus_i | input | 8 | Value seen on the shared bus |
| bus_o | output | 8 | Register contents offered to the bus |
| bus_oe_o | output | 1 | Bus driver enable |
| lsb_o | output | 1 | Serial tap on bit 0 |
| msb_o | output | 1 | Serial tap on bit 7 |

## Verification
Two stages are chained into one 16-bit shifter. The bench compares the chain against a 16-bit reference model after every edge.

An asymmetric load word separates upward shifts from downward shifts. It also shows whether any bit lane is swapped. A long serial pattern with runs and isolated bits is fed in each direction. This exposes a broken link between the stages or a wrong end-bit source, because the whole pattern must come out intact after sixteen shifts. During hold, the serial inputs are toggled, which shows whether hold truly ignores them. Every combination of the two enables, plus load mode, is applied to show which one lets the bus be driven. A reset dropped between clock edges separates an asynchronous clear from a synchronous one.

// File: rtl/usr_pkg.sv
package usr_pkg;
  typedef enum logic [1:0] {
    MODE_HOLD = 2'b00,
    MODE_UP   = 2'b01,
    MODE_DN   = 2'b10,
    MODE_LOAD = 2'b11
  } usr_mode_e;
endpackage

// File: rtl/usr_next.sv
module usr_next
  import usr_pkg::*;
#(
  parameter int W = 8
) (
  input  usr_mode_e      mode_i,
  input  logic [W-1:0]   q_i,
  input  logic [W-1:0]   load_i,
  input  logic           ser_up_i,
  input  logic           ser_dn_i,
  output logic [W-1:0]   d_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic from_lo, from_hi;
    if (i == 0) begin : g_lo_end
      assign from_lo = ser_up_i;
    end else begin : g_lo_mid
      assign from_lo = q_i[i-1];
    end
    if (i == W-1) begin : g_hi_end
      assign from_hi = ser_dn_i;
    end else begin : g_hi_mid
      assign from_hi = q_i[i+1];
    end
    always_comb begin
      case (mode_i)
        MODE_UP:   d_o[i] = from_lo;
        MODE_DN:   d_o[i] = from_hi;
        MODE_LOAD: d_o[i] = load_i[i];
        default:   d_o[i] = q_i[i];
      endcase
    end
  end
endmodule

// File: rtl/usr_bus_gate.sv
module usr_bus_gate
  import usr_pkg::*;
(
  input  usr_mode_e mode_i,
  input  logic      oe_a_ni,
  input  logic      oe_b_ni,
  output logic      oe_o
);
  // load mode releases the bus regardless of the enables
  assign oe_o = !oe_a_ni && !oe_b_ni && (mode_i != MODE_LOAD);
endmodule

// File: rtl/univ_shift_reg.sv
module univ_shift_reg
  import usr_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [1:0]   mode_i,
  input  logic         ser_up_i,
  input  logic         ser_dn_i,
  input  logic         oe_a_ni,
  input  logic         oe_b_ni,
  input  logic [W-1:0] bus_i,
  output logic [W-1:0] bus_o,
  output logic         bus_oe_o,
  output logic         lsb_o,
  output logic         msb_o
);
  localparam int MSB = W - 1;

  usr_mode_e    mode;
  logic [W-1:0] q_q, q_d;

  assign mode = usr_mode_e'(mode_i);

  usr_next #(.W(W)) u_next (
    .mode_i   (mode),
    .q_i      (q_q),
    .load_i   (bus_i),
    .ser_up_i (ser_up_i),
    .ser_dn_i (ser_dn_i),
    .d_o      (q_d)
  );

  usr_bus_gate u_gate (
    .mode_i  (mode),
    .oe_a_ni (oe_a_ni),
    .oe_b_ni (oe_b_ni),
    .oe_o    (bus_oe_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_q <= '0;
    else         q_q <= q_d;
  end

  assign bus_o = q_q;
  assign lsb_o = q_q[0];
  assign msb_o = q_q[MSB];

  always @(posedge clk_i) begin
    if (!rst_ni) AST_RST_CLEAR: assert (q_q == '0) else $error("reset"); // R1
  end

  AST_HOLD_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_i == 2'b00 |=> $stable(q_q)) else $error("hold"); // R2
  AST_LOAD_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_i == 2'b11 |=> q_q == $past(bus_i)) else $error("load"); // R3
  AST_SHIFT_UP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_i == 2'b01 |=> q_q == {$past(q_q[MSB-1:0]), $past(ser_up_i)}) else $error("up"); // R4
  AST_SHIFT_DN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_i == 2'b10 |=> q_q == {$past(ser_dn_i), $past(q_q[MSB:1])}) else $error("dn"); // R5
  AST_OE_LOAD_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'b11 || oe_a_ni || oe_b_ni) |-> !bus_oe_o) else $error("oe"); // R6
endmodule

// File: tb/sim_univ_shift_reg.sv
`timescale 1ns/1ps
module sim_univ_shift_reg;
  typedef struct {
    logic [15:0] val;
    string       tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b1;
  logic [1:0] mode = 2'b00;
  logic ser_in = 1'b0;
  logic oe_a_n = 1'b1, oe_b_n = 1'b1;
  logic [15:0] drv = '0;
  logic [15:0] ref_q = '0;
  int n_chk = 0, n_fail = 0;
  exp_t sb[$];

  wire  [15:0] bus_w;
  logic [7:0]  bo0, bo1;
  logic        oe0, oe1, lsb0, lsb1, msb0, msb1;
  logic        drv_en;

  assign drv_en = (mode == 2'b11);
  assign bus_w[7:0]  = oe0 ? bo0 : 8'bz;
  assign bus_w[15:8] = oe1 ? bo1 : 8'bz;
  assign bus_w       = drv_en ? drv : 16'bz;

  always #4 clk = ~clk;

  univ_shift_reg u0 (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .ser_up_i(ser_in), .ser_dn_i(lsb1),
    .oe_a_ni(oe_a_n), .oe_b_ni(oe_b_n), .bus_i(bus_w[7:0]), .bus_o(bo0),
    .bus_oe_o(oe0), .lsb_o(lsb0), .msb_o(msb0));
  univ_shift_reg u1 (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .ser_up_i(msb0), .ser_dn_i(ser_in),
    .oe_a_ni(oe_a_n), .oe_b_ni(oe_b_n), .bus_i(bus_w[15:8]), .bus_o(bo1),
    .bus_oe_o(oe1), .lsb_o(lsb1), .msb_o(msb1));

  task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // driver: apply one cycle and queue the expected chain value
  task automatic step(input logic [1:0] m, input logic s, input logic [15:0] d, input string tag);
    mode = m; ser_in = s; drv = d;
    @(posedge clk);
    case (m)
      2'b01: ref_q = {ref_q[14:0], s};
      2'b10: ref_q = {s, ref_q[15:1]};
      2'b11: ref_q = d;
      default: ref_q = ref_q;
    endcase
    sb.push_back('{val: ref_q, tag: tag});
    @(negedge clk);
  endtask

  // monitor
  initial begin
    forever begin
      @(negedge clk);
      while (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        chk({bo1, bo0} === e.val, e.tag, {bo1, bo0}, e.val);
        chk({msb1, lsb1, msb0, lsb0} === {e.val[15], e.val[8], e.val[7], e.val[0]},
            {e.tag, " R7 taps"}, {12'h0, msb1, lsb1, msb0, lsb0},
            {12'h0, e.val[15], e.val[8], e.val[7], e.val[0]});
      end
    end
  end

  initial begin
    #(8 * 200000);
    n_fail++; n_chk++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] pat;
    #1 rst_n = 1'b0;
    @(negedge clk); @(negedge clk);
    chk({bo1, bo0} === 16'h0, "R1 reset state", {bo1, bo0}, 16'h0);
    chk({msb1, lsb1, msb0, lsb0} === 4'h0, "R1 reset taps", {12'h0, msb1, lsb1, msb0, lsb0}, 16'h0);
    rst_n = 1'b1;

    step(2'b11, 1'b0, 16'hA5C3, "R3 load");
    step(2'b00, 1'b1, 16'hFFFF, "R2 hold");
    step(2'b00, 1'b0, 16'h0000, "R2 hold");
    step(2'b00, 1'b1, 16'h1234, "R2 hold");

    // R6 enable combinations in hold mode
    mode = 2'b00;
    for (int k = 0; k < 4; k++) begin
      {oe_a_n, oe_b_n} = 2'(k);
      #1;
      chk({oe1, oe0} === ((k == 0) ? 2'b11 : 2'b00), "R6 oe combo", {14'h0, oe1, oe0},
          (k == 0) ? 16'h3 : 16'h0);
      // R7 taps do not depend on enables
      chk({msb1, lsb0} === {ref_q[15], ref_q[0]}, "R7 taps vs oe", {14'h0, msb1, lsb0},
          {14'h0, ref_q[15], ref_q[0]});
    end
    oe_a_n = 1'b0; oe_b_n = 1'b0; #1;
    chk(bus_w === ref_q, "R6 bus readback", bus_w, ref_q);
    mode = 2'b11; #1;
    chk({oe1, oe0} === 2'b00, "R6 load releases bus", {14'h0, oe1, oe0}, 16'h0);
    @(negedge clk);
    mode = 2'b00;
    step(2'b11, 1'b0, 16'h0000, "R3 load zero");

    // R4 R8 upward through the chain
    pat = 16'h3B71;
    for (int i = 15; i >= 0; i--) step(2'b01, pat[i], 16'h0, "R4 R8 up");
    #1 chk(bus_w === pat, "R8 up pattern on bus", bus_w, pat);

    // R5 R8 downward through the chain
    pat = 16'hC80D;
    for (int i = 0; i < 16; i++) step(2'b10, pat[i], 16'h0, "R5 R8 down");
    #1 chk(bus_w === pat, "R8 down pattern on bus", bus_w, pat);

    // R1 asynchronous clear between edges
    oe_a_n = 1'b1;
    step(2'b11, 1'b0, 16'hFFFF, "R3 load ones");
    mode = 2'b00;
    #1 rst_n = 1'b0;
    #1 chk({bo1, bo0} === 16'h0, "R1 async clear", {bo1, bo0}, 16'h0);
    ref_q = '0;
    @(negedge clk) rst_n = 1'b1;
    step(2'b00, 1'b1, 16'h0, "R1 R2 after reset");

    @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule